// File: doc/BRIEF.md
# Zero-Address Stack Execution Unit

This block is a small stack-machine datapath. It executes arithmetic that names no operands at all, together with push and pop operations that each carry one operand. The arithmetic takes both of its inputs from the top two entries of an internal operand stack and leaves a single result in their place. A push puts either a literal constant or the contents of a data-memory word onto the stack. A pop removes the top entry and stores it at a memory address.

Instructions arrive on a valid/ready handshake. Each instruction is an opcode, a kind bit and a 16-bit data field. The unit drives a simple synchronous data-memory port: it presents an address, and the read data is due one clock edge later. Stack misuse does not change any state. Instead it raises one of two error flags, and each flag stays set until reset.

Top module: `stk_exec_unit`

## Requirements
- R1: After reset, `in_ready` is 1, both error flags are 0, `mem_we` is 0, and the stack holds no entries.
- R2: Opcode encoding is 0 for push, 1 for pop, 2 for add and 3 for subtract. The kind bit is 0 for a constant and 1 for a memory address. A pushed constant is the full 16-bit data field. Pops return entries in last-in, first-out order.
- R3: A push with kind 1 takes two cycles. In the accept cycle, `mem_addr` equals the low `AW` bits of the data field and `mem_we` is 0. In the next cycle `in_ready` is 0. `mem_rdata` is captured at the end of that second cycle and becomes the new top entry.
- R4: Add replaces the top two entries with their sum, modulo 2^16, and the depth drops by one.
- R5: Subtract replaces the top two entries with (second-from-top minus top), modulo 2^16.
- R6: In the accept cycle of a pop on a non-empty stack, `mem_we` is 1, `mem_addr` equals the low `AW` bits of the data field, and `mem_wdata` is the top entry. The write lands at that clock edge and the top entry is removed.
- R7: The sequence push-from-memory X, push constant 7, add, pop X leaves location X holding its old value plus 7.
- R8: A pop on an empty stack sets `err_underflow`, performs no memory write and leaves the stack unchanged.
- R9: Add or subtract with fewer than two entries sets `err_underflow` and leaves the stack unchanged.
- R10: A push of either kind onto a full stack (`DEPTH` = 8 entries) sets `err_overflow`, issues no memory access and leaves the stack unchanged.
- R11: Both error flags are sticky: once set, they stay 1 until reset.
- R12: A constant push, an add, a subtract and a pop each complete in one cycle, so `in_ready` stays 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Unit can accept an instruction |
| in_op | input | 2 | Opcode: 0 push, 1 pop, 2 add, 3 subtract |
| in_kind | input | 1 | Operand kind: 0 constant, 1 memory address |
| in_data | input | W | Constant value or address (low AW bits) |
| mem_addr | output | AW | Data-memory address |
| mem_wdata | output | W | Data-memory write data |
| mem_we | output | 1 | Data-memory write enable |
| mem_rdata | input | W | Data-memory read data, one edge after the address |
| err_overflow | output | 1 | Sticky overflow flag |
| err_underflow | output | 1 | Sticky underflow flag |

## Verification
The stack is visible only through pops, so a corrupted entry or a wrong stack pointer shows up at the first later pop that reaches it. It appears as a wrong `mem_wdata` value, a missing write, or an error flag that changes at the wrong moment. A miscounted depth shows up as soon as the stack is drained or filled: underflow or overflow appears one instruction too early or too late. A fault in the memory-push path shows up in the cycle after the accept, either as `in_ready` staying high or as a wrong value at the next pop.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [1:0] {
    OPC_PUSH = 2'd0,
    OPC_POP  = 2'd1,
    OPC_ADD  = 2'd2,
    OPC_SUB  = 2'd3
  } stk_op_e;

  typedef enum logic [1:0] {
    SRC_CONST = 2'd0,
    SRC_MEM   = 2'd1,
    SRC_ALU   = 2'd2
  } stk_src_e;

  // Arithmetic on two stack entries: lower is second-from-top, upper is top.
  function automatic logic [15:0] stk_arith(input logic is_sub,
                                            input logic [15:0] lower,
                                            input logic [15:0] upper);
    logic [15:0] r;
    if (is_sub) r = lower - upper;
    else        r = lower + upper;
    return r;
  endfunction

endpackage

// File: rtl/stk_regfile.sv
module stk_regfile #(
  parameter int DEPTH = 8,
  parameter int W     = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          do_push,
  input  logic          do_pop,
  input  logic          do_fold,
  input  logic [W-1:0]  wr_val,
  output logic [W-1:0]  top,
  output logic [W-1:0]  nxt,
  output logic [CW-1:0] cnt
);

  logic [W-1:0] ent [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (do_push) cnt <= cnt + CW'(1);
    else if (do_pop || do_fold) cnt <= cnt - CW'(1);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n) ent[i] <= '0;
      else if (do_push && int'(cnt) == i) ent[i] <= wr_val;
      else if (do_fold && int'(cnt) == i + 2) ent[i] <= wr_val;
    end
  end

  always_comb begin
    top = '0;
    nxt = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (int'(cnt) == i + 1) top = ent[i];
      if (int'(cnt) == i + 2) nxt = ent[i];
    end
  end

endmodule

// File: rtl/stk_alu.sv
module stk_alu #(
  parameter int W = 16
) (
  input  logic         is_sub,
  input  logic [W-1:0] lower,
  input  logic [W-1:0] upper,
  output logic [W-1:0] res
);

  always_comb res = W'(stk_pkg::stk_arith(is_sub, 16'(lower), 16'(upper)));

endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl #(
  parameter int DEPTH = 8,
  parameter int W     = 16,
  parameter int AW    = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [1:0]     in_op,
  input  logic           in_kind,
  input  logic [W-1:0]   in_data,
  input  logic [CW-1:0]  cnt,
  output logic           in_ready,
  output logic           fire,
  output logic           do_push,
  output logic           do_pop,
  output logic           do_fold,
  output stk_pkg::stk_src_e src_sel,
  output logic           rd_issue,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic           ovf_evt,
  output logic           unf_evt
);
  import stk_pkg::*;

  typedef enum logic {ST_IDLE, ST_READ} st_e;
  st_e st;

  logic full, empty, lt_two;
  stk_op_e op;

  assign op       = stk_op_e'(in_op);
  assign full     = (int'(cnt) == DEPTH);
  assign empty    = (cnt == '0);
  assign lt_two   = (int'(cnt) < 2);
  assign in_ready = (st == ST_IDLE);
  assign fire     = in_valid && in_ready;
  assign mem_addr = in_data[AW-1:0];

  always_comb begin
    do_push  = 1'b0;
    do_pop   = 1'b0;
    do_fold  = 1'b0;
    rd_issue = 1'b0;
    mem_we   = 1'b0;
    ovf_evt  = 1'b0;
    unf_evt  = 1'b0;
    src_sel  = SRC_CONST;
    if (st == ST_READ) begin
      do_push = 1'b1;
      src_sel = SRC_MEM;
    end else if (fire) begin
      unique case (op)
        OPC_PUSH: begin
          if (full) ovf_evt = 1'b1;
          else if (in_kind) rd_issue = 1'b1;
          else do_push = 1'b1;
        end
        OPC_POP: begin
          if (empty) unf_evt = 1'b1;
          else begin
            do_pop = 1'b1;
            mem_we = 1'b1;
          end
        end
        default: begin
          if (lt_two) unf_evt = 1'b1;
          else begin
            do_fold = 1'b1;
            src_sel = SRC_ALU;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else if (rd_issue) st <= ST_READ;
    else st <= ST_IDLE;
  end

endmodule

// File: rtl/stk_exec_unit.sv
module stk_exec_unit #(
  parameter int DEPTH = 8,
  parameter int W     = 16,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_op,
  input  logic          in_kind,
  input  logic [W-1:0]  in_data,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_wdata,
  output logic          mem_we,
  input  logic [W-1:0]  mem_rdata,
  output logic          err_overflow,
  output logic          err_underflow
);
  import stk_pkg::*;

  localparam int CW = $clog2(DEPTH + 1);

  logic          fire, do_push, do_pop, do_fold, rd_issue, ovf_evt, unf_evt;
  logic [W-1:0]  top, nxt, alu_res, wr_val;
  logic [CW-1:0] cnt;
  stk_src_e      src_sel;

  stk_ctrl #(.DEPTH(DEPTH), .W(W), .AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_kind(in_kind), .in_data(in_data), .cnt(cnt), .in_ready(in_ready),
    .fire(fire), .do_push(do_push), .do_pop(do_pop), .do_fold(do_fold),
    .src_sel(src_sel), .rd_issue(rd_issue), .mem_we(mem_we),
    .mem_addr(mem_addr), .ovf_evt(ovf_evt), .unf_evt(unf_evt)
  );

  stk_alu #(.W(W)) u_alu (
    .is_sub(in_op[0]), .lower(nxt), .upper(top), .res(alu_res)
  );

  always_comb begin
    unique case (src_sel)
      SRC_MEM: wr_val = mem_rdata;
      SRC_ALU: wr_val = alu_res;
      default: wr_val = in_data;
    endcase
  end

  stk_regfile #(.DEPTH(DEPTH), .W(W), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .do_push(do_push), .do_pop(do_pop),
    .do_fold(do_fold), .wr_val(wr_val), .top(top), .nxt(nxt), .cnt(cnt)
  );

  assign mem_wdata = top;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_overflow  <= 1'b0;
      err_underflow <= 1'b0;
    end else begin
      if (ovf_evt) err_overflow  <= 1'b1;
      if (unf_evt) err_underflow <= 1'b1;
    end
  end

endmodule

// File: rtl/stk_exec_unit_chk.sv
module stk_exec_unit_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          mem_we,
  input logic          err_overflow,
  input logic          err_underflow,
  input logic          rd_issue,
  input logic          do_fold,
  input logic          unf_evt,
  input logic          ovf_evt,
  input logic [CW-1:0] cnt
);

  a_r3_busy_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue |=> !in_ready);

  a_r3_single_wait: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);

  a_r8_no_write_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> cnt != '0);

  a_r9_underflow_keeps_depth: assert property (@(posedge clk) disable iff (!rst_n)
    unf_evt |=> $stable(cnt));

  a_r10_overflow_keeps_depth: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> $stable(cnt));

  a_r10_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= DEPTH);

  a_r4_fold_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    do_fold |=> cnt == $past(cnt) - CW'(1));

  a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow |=> err_overflow);

  a_r11_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_underflow |=> err_underflow);

endmodule

bind stk_exec_unit stk_exec_unit_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .mem_we(mem_we),
  .err_overflow(err_overflow), .err_underflow(err_underflow),
  .rd_issue(rd_issue), .do_fold(do_fold), .unf_evt(unf_evt),
  .ovf_evt(ovf_evt), .cnt(cnt)
);

// File: tb/sim_stk_exec_unit.sv
`timescale 1ns/1ps
module sim_stk_exec_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = 2'd0;
  logic        in_kind = 1'b0;
  logic [15:0] in_data = 16'd0;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic [15:0] mem_rdata;
  logic        err_overflow, err_underflow;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [15:0] mem [256];
  logic [15:0] mdl [8];
  int          mcnt = 0;
  logic        m_ovf = 1'b0, m_unf = 1'b0;

  always #2 clk = ~clk;

  stk_exec_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_kind(in_kind), .in_data(in_data),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .err_overflow(err_overflow),
    .err_underflow(err_underflow)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  function automatic logic [15:0] exp_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s = {1'b0, a} + {1'b0, b};
    return s[15:0];
  endfunction

  function automatic logic [15:0] exp_sub(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s = {1'b0, a} + {1'b0, ~b} + 17'd1;
    return s[15:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    mcnt = 0;
    m_ovf = 1'b0;
    m_unf = 1'b0;
  endtask

  task automatic issue(input logic [1:0] op, input logic kind, input logic [15:0] d);
    logic [7:0] a;
    bit mem_push;
    a = d[7:0];
    mem_push = 1'b0;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_op = op;
    in_kind = kind;
    in_data = d;
    #0.5;
    case (op)
      2'd0: begin
        if (mcnt == 8) begin
          chk(!mem_we, "R10 no access when full", mem_we, 0);
          m_ovf = 1'b1;
        end else if (kind) begin
          chk(mem_addr == a && !mem_we, "R3 read address", mem_addr, a);
          mem_push = 1'b1;
        end
      end
      2'd1: begin
        if (mcnt == 0) begin
          chk(!mem_we, "R8 no write on empty pop", mem_we, 0);
          m_unf = 1'b1;
        end else begin
          chk(mem_we && mem_addr == a, "R6 write strobe/address", {mem_we, mem_addr}, {1'b1, a});
          chk(mem_wdata == mdl[mcnt-1], "R6 R2 popped value", mem_wdata, mdl[mcnt-1]);
        end
      end
      default: if (mcnt < 2) m_unf = 1'b1;
    endcase
    @(posedge clk);
    #0.5;
    in_valid = 1'b0;
    case (op)
      2'd0: if (mcnt < 8) begin
        if (mem_push) begin
          @(negedge clk);
          chk(!in_ready, "R3 busy in second cycle", in_ready, 0);
          mdl[mcnt] = mem[a];
        end else mdl[mcnt] = d;
        mcnt++;
      end
      2'd1: if (mcnt > 0) mcnt--;
      default: if (mcnt >= 2) begin
        mdl[mcnt-2] = op[0] ? exp_sub(mdl[mcnt-2], mdl[mcnt-1])
                            : exp_add(mdl[mcnt-2], mdl[mcnt-1]);
        mcnt--;
      end
    endcase
    @(negedge clk);
    chk(in_ready, "R12 ready after instruction", in_ready, 1);
    chk(err_overflow == m_ovf, "R10 R11 overflow flag", err_overflow, m_ovf);
    chk(err_underflow == m_unf, "R8 R9 R11 underflow flag", err_underflow, m_unf);
  endtask

  initial begin
    logic [15:0] old;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 37 + 5);

    do_reset();
    #0.5;
    chk(in_ready && !mem_we && !err_overflow && !err_underflow, "R1 reset state",
        {in_ready, mem_we, err_overflow, err_underflow}, 4'b1000);
    issue(2'd1, 1'b0, 16'd3);
    chk(err_underflow, "R1 R8 empty after reset", err_underflow, 1);
    chk(mem[3] == 16'(3 * 37 + 5), "R8 memory untouched", mem[3], 3 * 37 + 5);

    do_reset();
    issue(2'd0, 1'b0, 16'h1234);
    issue(2'd2, 1'b0, 16'd0);
    chk(err_underflow, "R9 add with one entry", err_underflow, 1);
    issue(2'd1, 1'b0, 16'd40);
    chk(mem[40] == 16'h1234, "R9 stack unchanged", mem[40], 16'h1234);

    do_reset();
    old = mem[20];
    issue(2'd0, 1'b1, 16'd20);
    issue(2'd0, 1'b0, 16'd7);
    issue(2'd2, 1'b0, 16'd0);
    issue(2'd1, 1'b0, 16'd20);
    chk(mem[20] == old + 16'd7, "R7 X plus 7", mem[20], old + 16'd7);

    issue(2'd0, 1'b0, 16'd5);
    issue(2'd0, 1'b0, 16'd9);
    issue(2'd3, 1'b0, 16'd0);
    issue(2'd1, 1'b0, 16'd30);
    chk(mem[30] == 16'hFFFC, "R5 subtract order and wrap", mem[30], 16'hFFFC);
    issue(2'd0, 1'b0, 16'hFFFF);
    issue(2'd0, 1'b0, 16'd2);
    issue(2'd2, 1'b0, 16'd0);
    issue(2'd1, 1'b0, 16'd31);
    chk(mem[31] == 16'd1, "R4 add wraps", mem[31], 1);

    do_reset();
    for (int i = 0; i < 9; i++) issue(2'd0, 1'b0, 16'(16'hA000 + i));
    chk(err_overflow, "R10 overflow on ninth push", err_overflow, 1);
    issue(2'd0, 1'b1, 16'd50);
    for (int i = 0; i < 8; i++) issue(2'd1, 1'b0, 16'(60 + i));
    chk(mem[60] == 16'hA007 && mem[67] == 16'hA000, "R2 LIFO order", mem[60], 16'hA007);
    chk(err_overflow, "R11 overflow stays set", err_overflow, 1);

    do_reset();
    for (int n = 0; n < 500; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (n % 80 == 79) do_reset();
      else if (r < 35) issue(2'd0, 1'($urandom_range(0, 1)), 16'($urandom));
      else if (r < 65) issue(2'd1, 1'b0, 16'($urandom_range(0, 255)));
      else issue(2'(2 + $urandom_range(0, 1)), 1'b0, 16'($urandom));
    end

    finish_run();
  end

endmodule